// File: doc/BRIEF.md
# Serial Command Slave with Local Register File

This block is the slave end of a four-wire serial link (clock idle low, data sampled on the rising clock edge, mode 0). Each complete 8-bit word that arrives on the data-in line is a command. The command acts on a small local register file: digital input and output bytes, analog input and output bytes, a data register, a type and an offset identification byte, a 16-bit pointer, and a scratch RAM reached through that pointer. The host builds a byte value from two nibble commands. It then commits that value to a target register, or asks for a register to be staged as the reply. The staged reply is shifted out on the data-out line during the next byte transfer.

The serial lines are brought into the system clock domain through a two-flop synchronizer. A frame controller with four named states handles framing:
- **IDLE**: select is high; the input ports are sampled.
- **ACTIVE**: bits are shifting.
- **EXEC**: one cycle in which a complete byte is executed.
- **LOAD**: one cycle in which the staged reply is copied into the transmit shifter.

The transitions are:
- IDLE→ACTIVE on select low, which also loads the reply.
- ACTIVE→EXEC on the eighth rising clock edge.
- ACTIVE→IDLE on select high, which discards a partial byte.
- EXEC→LOAD, always.
- LOAD→ACTIVE while select stays low, or LOAD→IDLE otherwise.

The parallel output bytes are driven straight from the output registers.

Top module: `spi_cmd_slave`

## Requirements
- R1: Bits are taken MSB first on rising serial-clock edges while select is low. The reply shifts out MSB first: its MSB is presented from select low, or from the end of the previous byte, and each later bit follows a falling edge. Every 8 bits form one command that executes once.
- R2: A command with bits 7:5 = 000 is a nibble load. Bit 4 = 0 writes bits 3:0 into data bits 7:4, and bit 4 = 1 writes them into data bits 3:0; the other nibble is kept. So 0x0F then 0x1F gives data 0xFF.
- R3: A command with bits 7:6 = 10 stages a register as the reply, which is shifted out during the next byte, including in a later frame. Bit 5 selects digital (0) or analog (1), bit 4 selects input (0) or output (1), and bits 3:0 give the index. Examples: 0x80 selects digital input 0, and 0xA2 selects analog input byte 2. The staged reply changes only through R3 or the reply-loading sub-commands in R7 and R8.
- R4: A command with bits 7:6 = 11 writes the data register into the register chosen by the same fields as R3 (0xD3 targets digital output 3). Digital output byte i appears on dout[8i+7:8i], and analog output byte j appears on aout[8j+7:8j].
- R5: Digital indices 0–3 are valid. Analog indices 0–7 are valid, with even index = low byte and odd index = high byte of channel index/2. An out-of-range read returns 0x00 and an out-of-range write changes nothing.
- R6: Input registers load from din_pins/ain_pins every cycle while select is high. A commit to an input register can be read back within the same frame, and the next sample replaces it.
- R7: Sub-commands have bits 7:5 = 011. Sub-code 1 stages the type ID as the reply, and 2 stages the offset ID. Sub-code 3 writes data to the offset ID, and 4 writes data to the type ID.
- R8: Sub-code 6 writes data to pointer bits 7:0, and 7 writes it to pointer bits 15:8. Sub-code 8 stores data at RAM[pointer mod 64] and then increments the 16-bit pointer, which wraps. Sub-code 9 stores without increment. Sub-code A stages RAM[pointer mod 64] as the reply.
- R9: Bit 4 of a sub-command is ignored (0x71 acts as 0x61). Sub-codes 0, 5 and B–F are no-ops, as are 0x20–0x3F and 0x40–0x5F.
- R10: If select rises before the eighth bit, the partial byte is dropped, no command executes, and the next frame starts a fresh byte.
- R11: After reset the reply, data register, pointer, RAM and all output registers are 0x00. The type ID is 0x3C and the offset ID is 0x00 (default parameters).
- R12: dout and aout change only in the cycle after a command executes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from host, idle low |
| ss_n | input | 1 | Active-low select |
| mosi | input | 1 | Serial command data in |
| din_pins | input | 32 | Digital input port pins, byte i at [8i+7:8i] |
| ain_pins | input | 64 | Analog input bytes, byte j at [8j+7:8j] |
| miso | output | 1 | Serial reply data out |
| dout | output | 32 | Digital output registers |
| aout | output | 64 | Analog output registers |

## Verification
The hardest situation to reach is the one-transfer lag between a command and its reply. It is hardest when that lag spans a frame boundary, when input registers have been overwritten by commits and then resampled, and when the pointer wraps. The stimulus reaches these states with directed frames: a commit to an input register followed by a read-back in the same frame and in the next frame, a pointer set to 0xFFFF before an auto-incrementing store, and a truncated byte. Random frames of random command bytes then run against a reference model that checks every reply bit-stream and the parallel outputs after each frame.

// File: rtl/spicmd_pkg.sv
package spicmd_pkg;
    typedef enum logic [1:0] {
        OP_NIB  = 2'b00,
        OP_SUB  = 2'b01,
        OP_GET  = 2'b10,
        OP_PUT  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        FS_IDLE   = 2'd0,
        FS_ACTIVE = 2'd1,
        FS_EXEC   = 2'd2,
        FS_LOAD   = 2'd3
    } fstate_e;

    localparam logic [3:0] SC_GET_TYPE = 4'h1;
    localparam logic [3:0] SC_GET_OFS  = 4'h2;
    localparam logic [3:0] SC_SET_OFS  = 4'h3;
    localparam logic [3:0] SC_SET_TYPE = 4'h4;
    localparam logic [3:0] SC_PTR_LO   = 4'h6;
    localparam logic [3:0] SC_PTR_HI   = 4'h7;
    localparam logic [3:0] SC_ST_INC   = 4'h8;
    localparam logic [3:0] SC_ST       = 4'h9;
    localparam logic [3:0] SC_LD       = 4'hA;
endpackage

// File: rtl/spicmd_sync.sv
module spicmd_sync #(
    parameter int          W       = 3,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            meta <= RST_VAL;
            q    <= RST_VAL;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/spicmd_frame.sv
module spicmd_frame import spicmd_pkg::*; (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sclk_s,
    input  logic       mosi_s,
    input  logic       ss_s,
    input  logic [7:0] miso_hold,
    output fstate_e    st,
    output logic       cmd_valid,
    output logic [7:0] cmd_byte,
    output logic       sample_en,
    output logic       miso
);
    fstate_e    st_nx;
    logic       sclk_d;
    logic [2:0] bit_cnt;
    logic [7:0] rx_sr;
    logic [7:0] tx_sr;
    logic       rise, fall;

    assign rise = sclk_s & ~sclk_d;
    assign fall = ~sclk_s & sclk_d;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= FS_IDLE;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            FS_IDLE:   if (!ss_s) st_nx = FS_ACTIVE;
            FS_ACTIVE: begin
                if (ss_s)                        st_nx = FS_IDLE;
                else if (rise && bit_cnt == 3'd7) st_nx = FS_EXEC;
            end
            FS_EXEC:   st_nx = FS_LOAD;
            FS_LOAD:   st_nx = ss_s ? FS_IDLE : FS_ACTIVE;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_d  <= 1'b0;
            bit_cnt <= '0;
            rx_sr   <= '0;
            tx_sr   <= '0;
        end else begin
            sclk_d <= sclk_s;
            unique case (st)
                FS_IDLE: begin
                    bit_cnt <= '0;
                    if (!ss_s) tx_sr <= miso_hold;
                end
                FS_ACTIVE: begin
                    if (!ss_s) begin
                        if (rise) begin
                            rx_sr   <= {rx_sr[6:0], mosi_s};
                            bit_cnt <= bit_cnt + 3'd1;
                        end else if (fall && bit_cnt != 3'd0) begin
                            tx_sr <= {tx_sr[6:0], 1'b0};
                        end
                    end
                end
                FS_EXEC: ;
                FS_LOAD: tx_sr <= miso_hold;
            endcase
        end
    end

    assign cmd_valid = (st == FS_EXEC);
    assign cmd_byte  = rx_sr;
    assign sample_en = (st == FS_IDLE) && ss_s;
    assign miso      = tx_sr[7];
endmodule

// File: rtl/spicmd_exec.sv
module spicmd_exec import spicmd_pkg::*; #(
    parameter int         N_DIG     = 4,
    parameter int         N_AB      = 8,
    parameter int         MEM_DEPTH = 64,
    parameter logic [7:0] TYPE_RST  = 8'h3C,
    parameter logic [7:0] OFS_RST   = 8'h00
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [7:0]          cmd,
    input  logic                sample_en,
    input  logic [8*N_DIG-1:0]  din_pins,
    input  logic [8*N_AB-1:0]   ain_pins,
    output logic [8*N_DIG-1:0]  dout,
    output logic [8*N_AB-1:0]   aout,
    output logic [7:0]          miso_hold,
    output logic [7:0]          data_q,
    output logic [15:0]         ptr_q
);
    localparam int DIW = $clog2(N_DIG);
    localparam int AIW = $clog2(N_AB);
    localparam int MAW = $clog2(MEM_DEPTH);
    localparam logic [4:0] DLIM = 5'(N_DIG);
    localparam logic [4:0] ALIM = 5'(N_AB);

    logic [7:0] din_r  [N_DIG];
    logic [7:0] dout_r [N_DIG];
    logic [7:0] ain_r  [N_AB];
    logic [7:0] aout_r [N_AB];
    logic [7:0] mem    [MEM_DEPTH];
    logic [7:0] type_q, ofs_q;

    op_e            op;
    logic           is_ana, is_out, dig_ok, ana_ok;
    logic [3:0]     idx;
    logic [DIW-1:0] di;
    logic [AIW-1:0] ai;
    logic [MAW-1:0] ma;
    logic [7:0]     rd_val;

    assign op     = op_e'(cmd[7:6]);
    assign is_ana = cmd[5];
    assign is_out = cmd[4];
    assign idx    = cmd[3:0];
    assign di     = idx[DIW-1:0];
    assign ai     = idx[AIW-1:0];
    assign ma     = ptr_q[MAW-1:0];
    assign dig_ok = ({1'b0, idx} < DLIM);
    assign ana_ok = ({1'b0, idx} < ALIM);

    always_comb begin
        rd_val = 8'h00;
        if (!is_ana) begin
            if (dig_ok) rd_val = is_out ? dout_r[di] : din_r[di];
        end else begin
            if (ana_ok) rd_val = is_out ? aout_r[ai] : ain_r[ai];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < N_DIG; i++) begin
                din_r[i]  <= '0;
                dout_r[i] <= '0;
            end
            for (int i = 0; i < N_AB; i++) begin
                ain_r[i]  <= '0;
                aout_r[i] <= '0;
            end
            for (int i = 0; i < MEM_DEPTH; i++) mem[i] <= '0;
            miso_hold <= '0;
            data_q    <= '0;
            ptr_q     <= '0;
            type_q    <= TYPE_RST;
            ofs_q     <= OFS_RST;
        end else begin
            if (sample_en) begin
                for (int i = 0; i < N_DIG; i++) din_r[i] <= din_pins[8*i +: 8];
                for (int i = 0; i < N_AB; i++)  ain_r[i] <= ain_pins[8*i +: 8];
            end
            if (cmd_valid) begin
                unique case (op)
                    OP_NIB: if (!cmd[5]) begin
                        if (cmd[4]) data_q[3:0] <= cmd[3:0];
                        else        data_q[7:4] <= cmd[3:0];
                    end
                    OP_GET: miso_hold <= rd_val;
                    OP_PUT: begin
                        if (!is_ana) begin
                            if (dig_ok) begin
                                if (is_out) dout_r[di] <= data_q;
                                else        din_r[di]  <= data_q;
                            end
                        end else if (ana_ok) begin
                            if (is_out) aout_r[ai] <= data_q;
                            else        ain_r[ai]  <= data_q;
                        end
                    end
                    OP_SUB: if (cmd[5]) begin
                        case (cmd[3:0])
                            SC_GET_TYPE: miso_hold   <= type_q;
                            SC_GET_OFS:  miso_hold   <= ofs_q;
                            SC_SET_OFS:  ofs_q       <= data_q;
                            SC_SET_TYPE: type_q      <= data_q;
                            SC_PTR_LO:   ptr_q[7:0]  <= data_q;
                            SC_PTR_HI:   ptr_q[15:8] <= data_q;
                            SC_ST_INC: begin
                                mem[ma] <= data_q;
                                ptr_q   <= ptr_q + 16'd1;
                            end
                            SC_ST:       mem[ma]     <= data_q;
                            SC_LD:       miso_hold   <= mem[ma];
                            default: ;
                        endcase
                    end
                endcase
            end
        end
    end

    for (genvar g = 0; g < N_DIG; g++) begin : g_dout
        assign dout[8*g +: 8] = dout_r[g];
    end
    for (genvar g = 0; g < N_AB; g++) begin : g_aout
        assign aout[8*g +: 8] = aout_r[g];
    end
endmodule

// File: rtl/spi_cmd_slave.sv
module spi_cmd_slave import spicmd_pkg::*; #(
    parameter int         N_DIG     = 4,
    parameter int         N_AB      = 8,
    parameter int         MEM_DEPTH = 64,
    parameter logic [7:0] TYPE_RST  = 8'h3C,
    parameter logic [7:0] OFS_RST   = 8'h00
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sclk,
    input  logic               ss_n,
    input  logic               mosi,
    input  logic [8*N_DIG-1:0] din_pins,
    input  logic [8*N_AB-1:0]  ain_pins,
    output logic               miso,
    output logic [8*N_DIG-1:0] dout,
    output logic [8*N_AB-1:0]  aout
);
    logic       sclk_s, mosi_s, ss_s;
    fstate_e    st;
    logic       cmd_valid, sample_en;
    logic [7:0] cmd_byte, miso_hold, data_q;
    logic [15:0] ptr_q;

    spicmd_sync #(.W(3), .RST_VAL(3'b100)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     ({ss_n, sclk, mosi}),
        .q     ({ss_s, sclk_s, mosi_s})
    );

    spicmd_frame u_frame (
        .clk       (clk),
        .rst_n     (rst_n),
        .sclk_s    (sclk_s),
        .mosi_s    (mosi_s),
        .ss_s      (ss_s),
        .miso_hold (miso_hold),
        .st        (st),
        .cmd_valid (cmd_valid),
        .cmd_byte  (cmd_byte),
        .sample_en (sample_en),
        .miso      (miso)
    );

    spicmd_exec #(
        .N_DIG(N_DIG), .N_AB(N_AB), .MEM_DEPTH(MEM_DEPTH),
        .TYPE_RST(TYPE_RST), .OFS_RST(OFS_RST)
    ) u_exec (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd       (cmd_byte),
        .sample_en (sample_en),
        .din_pins  (din_pins),
        .ain_pins  (ain_pins),
        .dout      (dout),
        .aout      (aout),
        .miso_hold (miso_hold),
        .data_q    (data_q),
        .ptr_q     (ptr_q)
    );
endmodule

// File: rtl/spicmd_chk.sv
module spicmd_chk import spicmd_pkg::*; #(
    parameter int N_DIG = 4,
    parameter int N_AB  = 8
) (
    input logic               clk,
    input logic               rst_n,
    input fstate_e            st,
    input logic               ss_s,
    input logic               cmd_valid,
    input logic [7:0]         cmd_byte,
    input logic [7:0]         miso_hold,
    input logic [7:0]         data_q,
    input logic [15:0]        ptr_q,
    input logic [8*N_DIG-1:0] dout,
    input logic [8*N_AB-1:0]  aout
);
    // R10
    partial_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == FS_ACTIVE && ss_s) |=> (st == FS_IDLE));

    // R1
    single_exec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid |=> !cmd_valid);

    // R2
    hi_nibble_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte[7:4] == 4'b0000) |=>
        (data_q[7:4] == $past(cmd_byte[3:0]) && data_q[3:0] == $past(data_q[3:0])));

    // R3
    reply_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> $stable(miso_hold));

    // R3
    reply_dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte[7:4] == 4'b1001 && cmd_byte[3:0] < 4'(N_DIG)) |=>
        (miso_hold == $past(dout[8*int'(cmd_byte[3:0]) +: 8])));

    // R8
    ptr_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_byte[7:5] == 3'b011 && cmd_byte[3:0] == 4'h8) |=>
        (ptr_q == $past(ptr_q) + 16'd1));

    // R12
    out_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_valid |=> ($stable(dout) && $stable(aout)));
endmodule

bind spi_cmd_slave spicmd_chk #(.N_DIG(N_DIG), .N_AB(N_AB)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (st),
    .ss_s      (ss_s),
    .cmd_valid (cmd_valid),
    .cmd_byte  (cmd_byte),
    .miso_hold (miso_hold),
    .data_q    (data_q),
    .ptr_q     (ptr_q),
    .dout      (dout),
    .aout      (aout)
);

// File: tb/sim_spi_cmd_slave.sv
module sim_spi_cmd_slave;
    localparam int HALF = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        ss_n = 1'b1;
    logic        mosi = 1'b0;
    logic [31:0] din_pins = '0;
    logic [63:0] ain_pins = '0;
    logic        miso;
    logic [31:0] dout;
    logic [63:0] aout;

    always #2 clk = ~clk;

    spi_cmd_slave u0 (
        .clk(clk), .rst_n(rst_n), .sclk(sclk), .ss_n(ss_n), .mosi(mosi),
        .din_pins(din_pins), .ain_pins(ain_pins),
        .miso(miso), .dout(dout), .aout(aout)
    );

    // reference model
    logic [7:0]  m_din [4];
    logic [7:0]  m_dout[4];
    logic [7:0]  m_ain [8];
    logic [7:0]  m_aout[8];
    logic [7:0]  m_mem [64];
    logic [7:0]  m_data, m_type, m_ofs, m_miso;
    logic [15:0] m_ptr;

    int  n_chk = 0;
    int  n_fail = 0;
    bit  done = 0;

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wclk(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic logic [31:0] pk_d();
        logic [31:0] v;
        for (int i = 0; i < 4; i++) v[8*i +: 8] = m_dout[i];
        return v;
    endfunction

    function automatic logic [63:0] pk_a();
        logic [63:0] v;
        for (int i = 0; i < 8; i++) v[8*i +: 8] = m_aout[i];
        return v;
    endfunction

    task automatic m_sample();
        for (int i = 0; i < 4; i++) m_din[i] = din_pins[8*i +: 8];
        for (int i = 0; i < 8; i++) m_ain[i] = ain_pins[8*i +: 8];
    endtask

    function automatic logic [7:0] m_rd(input logic [7:0] c);
        if (!c[5]) return (c[3:0] < 4) ? (c[4] ? m_dout[c[1:0]] : m_din[c[1:0]]) : 8'h00;
        return (c[3:0] < 8) ? (c[4] ? m_aout[c[2:0]] : m_ain[c[2:0]]) : 8'h00;
    endfunction

    task automatic m_exec(input logic [7:0] c);
        case (c[7:6])
            2'b00: if (!c[5]) begin
                if (c[4]) m_data[3:0] = c[3:0];
                else      m_data[7:4] = c[3:0];
            end
            2'b10: m_miso = m_rd(c);
            2'b11: begin
                if (!c[5]) begin
                    if (c[3:0] < 4) begin
                        if (c[4]) m_dout[c[1:0]] = m_data; else m_din[c[1:0]] = m_data;
                    end
                end else if (c[3:0] < 8) begin
                    if (c[4]) m_aout[c[2:0]] = m_data; else m_ain[c[2:0]] = m_data;
                end
            end
            default: if (c[5]) begin
                case (c[3:0])
                    4'h1: m_miso = m_type;
                    4'h2: m_miso = m_ofs;
                    4'h3: m_ofs = m_data;
                    4'h4: m_type = m_data;
                    4'h6: m_ptr[7:0] = m_data;
                    4'h7: m_ptr[15:8] = m_data;
                    4'h8: begin m_mem[m_ptr[5:0]] = m_data; m_ptr = m_ptr + 16'd1; end
                    4'h9: m_mem[m_ptr[5:0]] = m_data;
                    4'hA: m_miso = m_mem[m_ptr[5:0]];
                    default: ;
                endcase
            end
        endcase
    endtask

    task automatic fbegin();
        ss_n = 1'b0;
        wclk(8);
    endtask

    task automatic fend();
        wclk(HALF);
        ss_n = 1'b1;
        wclk(8);
        m_sample();
    endtask

    // one byte: checks reply against the model and advances the model (R1)
    task automatic xb(input logic [7:0] c, input string tag);
        logic [7:0] rx;
        for (int i = 7; i >= 0; i--) begin
            mosi = c[i];
            wclk(HALF);
            rx[i] = miso;
            sclk = 1'b1;
            wclk(HALF);
            sclk = 1'b0;
        end
        chk({tag, " reply"}, {56'd0, rx}, {56'd0, m_miso});
        m_exec(c);
    endtask

    task automatic xpartial(input logic [7:0] c, input int nb);
        for (int i = 7; i > 7 - nb; i--) begin
            mosi = c[i];
            wclk(HALF);
            sclk = 1'b1;
            wclk(HALF);
            sclk = 1'b0;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        for (int i = 0; i < 4; i++) begin m_dout[i] = 0; end
        for (int i = 0; i < 8; i++) begin m_aout[i] = 0; end
        for (int i = 0; i < 64; i++) m_mem[i] = 0;
        m_data = 0; m_type = 8'h3C; m_ofs = 8'h00; m_miso = 0; m_ptr = 0;
        din_pins = 32'hA1B2C3D4;
        ain_pins = 64'h1122334455667788;
        m_sample();
        wclk(5);
        rst_n = 1'b1;
        wclk(10);

        // R11 reset state
        chk("R11 dout", {32'd0, dout}, 64'd0);
        chk("R11 aout", aout, 64'd0);
        chk("R11 miso", {63'd0, miso}, 64'd0);

        // R2 nibble loads, R4 commit, R3 reply of digital/analog
        fbegin();
        xb(8'h0F, "R2 hi");
        xb(8'h1F, "R2 lo");
        xb(8'hD3, "R4 dout3");
        xb(8'h93, "R3 get dout3");
        xb(8'h80, "R3 get din0");
        xb(8'hA2, "R3 get ain2");
        xb(8'h00, "R3 ain2 value");
        fend();
        chk("R4 dout after commit", {32'd0, dout}, {32'd0, pk_d()});
        chk("R2 data via dout3", {56'd0, dout[31:24]}, 64'hFF);

        // R4 R5 analog commit, odd index high byte
        fbegin();
        xb(8'h05, "R2 hi5");
        xb(8'h1A, "R2 loA");
        xb(8'hF5, "R5 aout5");
        xb(8'hB5, "R5 get aout5");
        xb(8'hD7, "R5 oob write");
        xb(8'h84, "R5 oob read");
        xb(8'hBC, "R5 oob ana read");
        fend();
        chk("R5 aout byte5", {56'd0, aout[47:40]}, 64'h5A);
        chk("R5 aout all", aout, pk_a());
        chk("R5 dout unchanged", {32'd0, dout}, {32'd0, pk_d()});

        // R6 commit to input, read back, then resampled
        din_pins = 32'h0000_7700;
        wclk(10);
        m_sample();
        fbegin();
        xb(8'h0C, "R6 hi");
        xb(8'h13, "R6 lo");
        xb(8'hC1, "R6 commit din1");
        xb(8'h81, "R6 get din1");
        xb(8'h00, "R6 committed value");
        fend();
        fbegin();
        xb(8'h81, "R6 get din1 again");
        xb(8'h00, "R6 resampled value");
        fend();

        // R7 identification
        fbegin();
        xb(8'h61, "R7 type");
        xb(8'h62, "R7 type value");
        xb(8'h09, "R7 hi");
        xb(8'h16, "R7 lo");
        xb(8'h64, "R7 set type");
        xb(8'h63, "R7 set ofs");
        xb(8'h71, "R9 bit4 type");
        xb(8'h72, "R9 type value");
        xb(8'h00, "R7 ofs value");
        fend();

        // R8 pointer, store with increment and wrap, load
        fbegin();
        xb(8'h0F, "R8 hi"); xb(8'h1F, "R8 lo");
        xb(8'h66, "R8 ptr lo"); xb(8'h67, "R8 ptr hi");
        xb(8'h04, "R8 d hi"); xb(8'h12, "R8 d lo");
        xb(8'h68, "R8 store inc wrap");
        xb(8'h6A, "R8 load at 0");
        xb(8'h69, "R8 store");
        xb(8'h6A, "R8 load stored");
        xb(8'h00, "R8 value");
        fend();

        // R9 reserved no-ops keep reply
        fbegin();
        xb(8'h61, "R9 prime");
        xb(8'h60, "R9 s0");
        xb(8'h65, "R9 s5");
        xb(8'h6B, "R9 sB");
        xb(8'h6F, "R9 sF");
        xb(8'h2F, "R9 0x2F");
        xb(8'h48, "R9 0x48");
        xb(8'h00, "R9 reply kept");
        fend();

        // R10 partial byte dropped
        fbegin();
        xb(8'h0A, "R10 hi");
        xb(8'h1A, "R10 lo");
        xpartial(8'hD0, 5);
        fend();
        chk("R10 dout unchanged", {32'd0, dout}, {32'd0, pk_d()});
        fbegin();
        xb(8'h90, "R10 fresh byte");
        xb(8'h00, "R10 dout0 value");
        fend();

        // random frames
        for (int f = 0; f < 40; f++) begin
            int nb;
            din_pins = $urandom;
            ain_pins = {$urandom, $urandom};
            wclk(10);
            m_sample();
            fbegin();
            nb = 1 + int'($urandom % 6);
            for (int b = 0; b < nb; b++) begin
                logic [7:0] c;
                c = 8'($urandom);
                if ($urandom % 2 == 1) c[3] = 1'b0;
                xb(c, "R1 random");
            end
            fend();
            chk("R4 random dout", {32'd0, dout}, {32'd0, pk_d()});
            chk("R12 random aout", aout, pk_a());
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule